// File: doc/BRIEF.md
# Write-Data Lane Driver for a Pipelined Bus Master

This block is the write side of a bus master on a pipelined system bus. Reads and writes use separate 32-bit data buses, so nothing on the write side ever tristates. A client presents a write request made of an address, a transfer size and a data value. The block first checks that the address suits the size. An aligned request is launched as an address phase. In the data phase that follows, the block drives the write data bus with the narrow value copied into every byte lane.

The slave can stretch either phase by holding the ready line low. While it does, the block holds the address-phase outputs and the write data unchanged. A misaligned request, or one with an unknown size code, never reaches the bus. Instead the block raises a one-cycle error pulse. Only one address phase and one data phase are in flight at a time, and they overlap in the usual pipelined way.

Top module: `wdl_write_master`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `bus_trans` is 00 (idle), `bus_wdata` is zero, `req_misalign` is low and `req_ready` is high.
- R2: A request taken at a clock edge with `req_valid` and `req_ready` both high, and that passes the alignment check, appears in the next cycle as an address phase: `bus_trans` = 10, `bus_write` = 1, `bus_addr` and `bus_size` equal to the request. The phase stays unchanged until a cycle in which `bus_ready` is high.
- R3: Size code 000 (byte) drives the low 8 bits of the request data into all four byte lanes. For example, 0x12 becomes 0x12121212.
- R4: Size code 001 (halfword) drives the low 16 bits into both halves. For example, 0x1234 becomes 0x12341234.
- R5: Size code 010 (word) drives the 32-bit request data unchanged.
- R6: The write data for a transfer is on `bus_wdata` in the cycle after its address phase completes, that is, after the cycle in which `bus_trans` = 10 and `bus_ready` = 1.
- R7: While `bus_ready` is low during a data phase, `bus_wdata` holds its value until the cycle in which `bus_ready` is sampled high.
- R8: A word request needs address bits [1:0] = 00. A halfword request needs address bit 0 = 0. Byte requests may use any address. A request that breaks these rules is consumed but not issued: in the next cycle `req_misalign` is high for one cycle and `bus_trans` is 00. An aligned request leaves `req_misalign` low.
- R9: Size codes 011 through 111 are rejected in the same way as a misaligned request.
- R10: `req_ready` is high when no address phase is pending, or when the pending one completes in this cycle (`bus_ready` high). It is low while an address phase is stretched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Write request present |
| req_addr | input | ADDR_W | Request byte address |
| req_size | input | 3 | Request size: 000 byte, 001 halfword, 010 word |
| req_data | input | DATA_W | Request data, right-justified |
| req_ready | output | 1 | Request taken (issued or rejected) at this edge |
| req_misalign | output | 1 | One-cycle pulse for a rejected request |
| bus_ready | input | 1 | Slave ready; low stretches the current phase |
| bus_trans | output | 2 | Transfer type: 00 idle, 10 non-sequential |
| bus_write | output | 1 | Write indication during an address phase |
| bus_addr | output | ADDR_W | Address-phase address |
| bus_size | output | 3 | Address-phase size |
| bus_wdata | output | DATA_W | Write data bus, lane-replicated |

## Verification
The bench builds the block with DATA_W = 32, so all four byte lanes and both halfword halves take part in replication. It sets ADDR_W = 16, which keeps addresses short while leaving both low address bits free for every alignment case. A pseudo-random ready pattern stretches address and data phases by varying amounts. This exercises holds that start while a new address phase waits behind a stretched data phase. It also covers back-to-back issue when `bus_ready` stays high.

// File: rtl/wdl_pkg.sv
package wdl_pkg;

  localparam int unsigned SIZE_W = 3;

  localparam logic [SIZE_W-1:0] SZ_BYTE = 3'b000;
  localparam logic [SIZE_W-1:0] SZ_HALF = 3'b001;
  localparam logic [SIZE_W-1:0] SZ_WORD = 3'b010;

  localparam logic [1:0] TR_IDLE   = 2'b00;
  localparam logic [1:0] TR_NONSEQ = 2'b10;

  localparam int unsigned LANE_W = 8;

endpackage

// File: rtl/wdl_align_chk.sv
module wdl_align_chk
  import wdl_pkg::*;
(
  input  logic [1:0]        addr_lo,
  input  logic [SIZE_W-1:0] size,
  output logic              aligned
);

  always_comb begin
    case (size)
      SZ_BYTE: aligned = 1'b1;
      SZ_HALF: aligned = (addr_lo[0] == 1'b0);
      SZ_WORD: aligned = (addr_lo == 2'b00);
      default: aligned = 1'b0;
    endcase
  end

endmodule

// File: rtl/wdl_lane_rep.sv
module wdl_lane_rep
  import wdl_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [SIZE_W-1:0] size,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  localparam int unsigned LANES = DATA_W / LANE_W;

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    localparam int unsigned HALF_SRC = (ln % 2) * LANE_W;
    localparam int unsigned WORD_SRC = (ln % 4) * LANE_W;
    always_comb begin
      case (size)
        SZ_BYTE: dout[ln*LANE_W +: LANE_W] = din[LANE_W-1:0];
        SZ_HALF: dout[ln*LANE_W +: LANE_W] = din[HALF_SRC +: LANE_W];
        default: dout[ln*LANE_W +: LANE_W] = din[WORD_SRC +: LANE_W];
      endcase
    end
  end

endmodule

// File: rtl/wdl_addr_stage.sv
module wdl_addr_stage
  import wdl_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_en,
  input  logic              take,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [SIZE_W-1:0] size_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              busy_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [SIZE_W-1:0] size_q,
  output logic [DATA_W-1:0] data_q
);

  logic              busy_d;
  logic [ADDR_W-1:0] addr_d;
  logic [SIZE_W-1:0] size_d;
  logic [DATA_W-1:0] data_d;

  always_comb begin
    busy_d = busy_q;
    addr_d = addr_q;
    size_d = size_q;
    data_d = data_q;
    if (adv_en) begin
      busy_d = take;
      if (take) begin
        addr_d = addr_in;
        size_d = size_in;
        data_d = data_in;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      addr_q <= '0;
      size_q <= SZ_BYTE;
      data_q <= '0;
    end else begin
      busy_q <= busy_d;
      addr_q <= addr_d;
      size_q <= size_d;
      data_q <= data_d;
    end
  end

endmodule

// File: rtl/wdl_data_stage.sv
module wdl_data_stage #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [DATA_W-1:0] d_in,
  output logic [DATA_W-1:0] d_q
);

  logic [DATA_W-1:0] d_next;

  always_comb begin
    d_next = d_q;
    if (load_en) d_next = d_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) d_q <= '0;
    else        d_q <= d_next;
  end

endmodule

// File: rtl/wdl_write_master.sv
module wdl_write_master
  import wdl_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_size,
  input  logic [DATA_W-1:0] req_data,
  output logic              req_ready,
  output logic              req_misalign,
  input  logic              bus_ready,
  output logic [1:0]        bus_trans,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [2:0]        bus_size,
  output logic [DATA_W-1:0] bus_wdata
);

  logic              aligned;
  logic              take;
  logic              reject;
  logic              ap_busy;
  logic [DATA_W-1:0] rep_data;
  logic [DATA_W-1:0] ap_data;
  logic              ap_done;
  logic              err_d;
  logic              err_q;

  wdl_align_chk u_align (
    .addr_lo (req_addr[1:0]),
    .size    (req_size),
    .aligned (aligned)
  );

  wdl_lane_rep #(.DATA_W(DATA_W)) u_rep (
    .size (req_size),
    .din  (req_data),
    .dout (rep_data)
  );

  // The address slot can move when it is empty or its phase ends now.
  assign req_ready = !ap_busy || bus_ready;
  assign take      = req_valid && req_ready && aligned;
  assign reject    = req_valid && req_ready && !aligned;
  assign ap_done   = ap_busy && bus_ready;

  wdl_addr_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv_en  (req_ready),
    .take    (take),
    .addr_in (req_addr),
    .size_in (req_size),
    .data_in (rep_data),
    .busy_q  (ap_busy),
    .addr_q  (bus_addr),
    .size_q  (bus_size),
    .data_q  (ap_data)
  );

  wdl_data_stage #(.DATA_W(DATA_W)) u_data (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (ap_done),
    .d_in    (ap_data),
    .d_q     (bus_wdata)
  );

  always_comb err_d = reject;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign req_misalign = err_q;
  assign bus_trans    = ap_busy ? TR_NONSEQ : TR_IDLE;
  assign bus_write    = ap_busy;

endmodule

// File: rtl/wdl_write_master_chk.sv
module wdl_write_master_chk
  import wdl_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_misalign,
  input logic              bus_ready,
  input logic [1:0]        bus_trans,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [2:0]        bus_size,
  input logic [DATA_W-1:0] bus_wdata
);

  localparam int unsigned LANES = DATA_W / LANE_W;

  logic in_data;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_data <= 1'b0;
    else        in_data <= (bus_trans == TR_NONSEQ && bus_ready) || (in_data && !bus_ready);
  end

  a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_trans == TR_NONSEQ && !bus_ready) |=>
      (bus_trans == TR_NONSEQ && bus_write && $stable(bus_addr) && $stable(bus_size)));

  a_r3_byte_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_trans == TR_NONSEQ && bus_ready && bus_size == SZ_BYTE) |=>
      (bus_wdata == {LANES{bus_wdata[7:0]}}));

  a_r4_half_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_trans == TR_NONSEQ && bus_ready && bus_size == SZ_HALF) |=>
      (bus_wdata == {(LANES/2){bus_wdata[15:0]}}));

  a_r7_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && !bus_ready) |=> $stable(bus_wdata));

  a_r8_no_issue: assert property (@(posedge clk) disable iff (!rst_n)
    req_misalign |-> (bus_trans == TR_IDLE && $past(req_valid && req_ready)));

  a_r10_stall_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_trans == TR_NONSEQ && !bus_ready) |-> !req_ready);

endmodule

bind wdl_write_master wdl_write_master_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_misalign (req_misalign),
  .bus_ready    (bus_ready),
  .bus_trans    (bus_trans),
  .bus_write    (bus_write),
  .bus_addr     (bus_addr),
  .bus_size     (bus_size),
  .bus_wdata    (bus_wdata)
);

// File: tb/tb_wdl_write_master.sv
`timescale 1ns/1ps
module tb_wdl_write_master;

  localparam int unsigned AW = 16;
  localparam int unsigned DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic [AW-1:0] req_addr;
  logic [2:0]    req_size;
  logic [DW-1:0] req_data;
  logic          req_ready;
  logic          req_misalign;
  logic          bus_ready;
  logic [1:0]    bus_trans;
  logic          bus_write;
  logic [AW-1:0] bus_addr;
  logic [2:0]    bus_size;
  logic [DW-1:0] bus_wdata;

  int n_chk = 0;
  int n_bad = 0;
  bit stall_mode = 1'b0;
  bit done = 1'b0;

  logic [AW+2:0] aq[$];
  logic [DW-1:0] dq[$];

  always #10 clk = ~clk;

  wdl_write_master #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr), .req_size(req_size), .req_data(req_data),
    .req_ready(req_ready), .req_misalign(req_misalign),
    .bus_ready(bus_ready), .bus_trans(bus_trans), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] lanes(input logic [2:0] sz, input logic [DW-1:0] d);
    case (sz)
      3'b000:  return {4{d[7:0]}};
      3'b001:  return {2{d[15:0]}};
      default: return d;
    endcase
  endfunction

  function automatic bit is_ok(input logic [AW-1:0] a, input logic [2:0] sz);
    case (sz)
      3'b000:  return 1'b1;
      3'b001:  return a[0] == 1'b0;
      3'b010:  return a[1:0] == 2'b00;
      default: return 1'b0;
    endcase
  endfunction

  // ready pattern, changed just after each rising edge
  initial begin
    bus_ready = 1'b1;
    forever begin
      @(posedge clk);
      #1 bus_ready = stall_mode ? ($urandom % 3 != 0) : 1'b1;
    end
  end

  // driver: pushes expected address-phase items
  task automatic send(input logic [AW-1:0] a, input logic [2:0] sz, input logic [DW-1:0] d, input string tag);
    bit good;
    good = is_ok(a, sz);
    @(posedge clk); #2;
    req_valid = 1'b1; req_addr = a; req_size = sz; req_data = d;
    do @(negedge clk); while (!req_ready);
    if (good) aq.push_back({sz, a});
    if (good) dq.push_back(lanes(sz, d));
    @(posedge clk); #2;
    req_valid = 1'b0;
    @(negedge clk);
    if (good) check(req_misalign == 1'b0, {tag, " R8 no false flag"}, 64'(req_misalign), 64'd0);
    else begin
      check(req_misalign == 1'b1, {tag, " R8/R9 reject pulse"}, 64'(req_misalign), 64'd1);
      check(bus_trans == 2'b00, {tag, " R8/R9 not issued"}, 64'(bus_trans), 64'd0);
    end
  endtask

  // monitor: compares bus activity against the queues
  int dptr = 0;
  bit in_dp = 1'b0;
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (in_dp) begin
          check(bus_wdata == dq[dptr], "R3/R4/R5/R6/R7 write data", 64'(bus_wdata), 64'(dq[dptr]));
          if (bus_ready) begin
            dptr++;
            in_dp = 1'b0;
          end
        end
        if (bus_trans == 2'b10 && !bus_ready)
          check(req_ready == 1'b0, "R10 ready low while stretched", 64'(req_ready), 64'd0);
        if (bus_trans == 2'b10 && bus_ready) begin
          if (aq.size() == 0) check(1'b0, "R2 unexpected address phase", 64'(bus_addr), 64'd0);
          else begin
            check({bus_size, bus_addr} == aq[0] && bus_write, "R2 address phase",
                  64'({bus_size, bus_addr}), 64'(aq[0]));
            void'(aq.pop_front());
          end
          in_dp = 1'b1;
        end
      end
    end
  end

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        if (!done) begin
          check(1'b0, "watchdog", 64'd0, 64'd1);
          $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
          $finish;
        end
      end
    join_none

    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_size = '0; req_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(bus_trans == 2'b00, "R1 idle in reset", 64'(bus_trans), 64'd0);
    check(bus_wdata == '0, "R1 wdata zero", 64'(bus_wdata), 64'd0);
    check(req_misalign == 1'b0 && req_ready == 1'b1, "R1 flags", 64'({req_misalign, req_ready}), 64'd1);
    #3 rst_n = 1'b1;
    @(negedge clk);
    check(bus_trans == 2'b00 && bus_wdata == '0, "R1 after release", 64'(bus_trans), 64'd0);

    // fixed patterns, ready held high
    send(16'h0003, 3'b000, 32'h0000_0012, "byte R3");
    send(16'h0002, 3'b001, 32'h0000_1234, "half R4");
    send(16'h0010, 3'b010, 32'hCAFE_F00D, "word R5");
    send(16'h0101, 3'b000, 32'hFFFF_FFA5, "byte hi bits R3");
    send(16'h0200, 3'b001, 32'hDEAD_BEEF, "half hi bits R4");
    send(16'h0001, 3'b010, 32'h1111_1111, "word off1 R8");
    send(16'h0002, 3'b010, 32'h2222_2222, "word off2 R8");
    send(16'h0003, 3'b001, 32'h3333_3333, "half odd R8");
    send(16'h0004, 3'b011, 32'h4444_4444, "size3 R9");
    send(16'h0000, 3'b111, 32'h5555_5555, "size7 R9");
    send(16'h0024, 3'b010, 32'h0BAD_C0DE, "word after reject R5");

    // stretched phases, random traffic
    stall_mode = 1'b1;
    for (int i = 0; i < 60; i++) begin
      logic [2:0] sz;
      logic [AW-1:0] a;
      sz = 3'($urandom % 4);
      a  = AW'($urandom);
      if (i % 5 != 0 && sz != 3'b011) begin
        if (sz == 3'b010) a[1:0] = 2'b00;
        if (sz == 3'b001) a[0] = 1'b0;
      end
      send(a, sz, $urandom, "random R6 R7");
    end
    stall_mode = 1'b0;
    repeat (10) @(posedge clk);
    @(negedge clk);
    check(aq.size() == 0 && dptr == dq.size(), "R2/R6 all transfers drained",
          64'(aq.size()), 64'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule